// File: doc/BRIEF.md
# Read-Handshaked Circular Byte FIFO

This block is a receive-side byte buffer built as a circular array. On the write side a producer presents a byte with a valid strobe. The byte goes into storage whenever the buffer has room and the block is enabled. The write side has no acknowledge: the `full` flag is its only back-pressure. A producer that raises `wr_valid` while `full` is high loses that byte, so it must hold off until `full` falls.

On the read side a consumer uses a four-phase request/acknowledge exchange. It raises `rd_req`. When the buffer holds data, the block takes the oldest byte and raises `rd_ack`. It presents that byte on `rd_data` and keeps it there. The block then stays locked with `rd_ack` high until the consumer drops `rd_req`. So a request held high takes exactly one byte, however long it stays high. The read pointer names the slot that was last consumed, so one slot is always unused and the buffer holds at most DEPTH-2 bytes.

Both flags and the occupancy count come from the pointer registers. A synchronous clear and an asynchronous reset both bring the buffer back to its empty state. A global enable freezes all data movement while it is low.

Top module: `hsk_rd_fifo`

## Requirements
- R1: After asynchronous reset, `empty`=1, `full`=0, `level`=0, `rd_ack`=0 and `rd_data`=0.
- R2: A write is accepted when `wr_valid`=1, `full`=0 and `en`=1. After that clock edge, `level` has risen by one.
- R3: A write offered while `full`=1 is dropped. `level` stays at DEPTH-2, and the bytes already stored are read back unchanged.
- R4: A read is accepted when `rd_req`=1, `empty`=0, `rd_ack`=0 and `en`=1. After that edge, `rd_ack`=1, `rd_data` holds the oldest stored byte and `level` has fallen by one.
- R5: While `rd_ack`=1 and `rd_req` stays high, no further byte is taken. `rd_ack`, `rd_data` and `level` do not change due to reads.
- R6: `rd_ack` is low after any edge at which `rd_req` was low. After one such cycle, a new request can be accepted.
- R7: `empty` and `full` reflect the pointer state before the current cycle's operations. A read requested while `empty`=1 is not accepted, even when a write is accepted in the same cycle.
- R8: `rd_data` changes only at an accepted read or a clear, and holds its value in between.
- R9: Bytes come out in the order they were written, including across the wrap from the last slot to slot 0.
- R10: `full`=1 exactly when `level`=DEPTH-2 (1022 by default). `empty`=1 exactly when `level`=0. The two flags are never high together.
- R11: While `en`=0, neither reads nor writes take effect.
- R12: A read and a write may both be accepted in one cycle. `level` is then unchanged and both bytes are handled.
- R13: `clr` overrides all other inputs. After the edge where `clr`=1, the block is in the R1 state, and any write or read offered in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, highest priority |
| en | input | 1 | Global enable for reads and writes |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | W (8) | Byte to store |
| rd_req | input | 1 | Read request (four-phase) |
| rd_ack | output | 1 | Read acknowledge, high from the accepting edge until the edge after `rd_req` falls |
| rd_data | output | W (8) | Registered byte from the last accepted read |
| empty | output | 1 | No stored bytes |
| full | output | 1 | DEPTH-2 bytes stored |
| level | output | log2(DEPTH) (10) | Number of stored bytes |

## Verification
Every result is due one rising edge after its stimulus. `rd_ack` and `rd_data` are registers. `empty`, `full` and `level` decode the pointer registers without a further stage, so they also settle right after the edge that moved the pointers. The bench changes inputs just after a falling edge and reads the outputs at the next falling edge. Each check therefore sees exactly the state produced by the one rising edge in between.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int HRF_DEPTH = 1024;
  localparam int HRF_W     = 8;

  typedef struct packed {
    logic rd;
    logic wr;
  } hrf_ops_t;
endpackage

// File: rtl/hrf_ptr.sv
module hrf_ptr #(
  parameter int DEPTH   = 1024,
  parameter int RST_VAL = 0,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_inc
);
  localparam logic [AW-1:0] RST_P = AW'(RST_VAL);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign ptr_inc = ptr + AW'(1);
    end else begin : g_cmp
      assign ptr_inc = (ptr == LAST) ? '0 : ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= RST_P;
    else if (clr)   ptr <= RST_P;
    else if (adv)   ptr <= ptr_inc;
  end
endmodule

// File: rtl/hrf_mem.sv
module hrf_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slots [DEPTH];

  // storage array, no reset so it maps onto block memory
  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  // registered output byte, loaded only on an accepted read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata <= '0;
    else if (clr) rdata <= '0;
    else if (re)  rdata <= slots[raddr];
  end
endmodule

// File: rtl/hrf_hsk.sv
module hrf_hsk (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic rd_req,
  input  logic empty,
  output logic rd_take,
  output logic rd_ack
);
  logic lock_q;

  // a byte is taken only on a fresh request
  assign rd_take = en & rd_req & ~empty & ~lock_q & ~clr;
  assign rd_ack  = lock_q;

  // lock holds while the request stays up, drops when it falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lock_q <= 1'b0;
    else if (clr) lock_q <= 1'b0;
    else          lock_q <= rd_req & (lock_q | rd_take);
  end
endmodule

// File: rtl/hrf_lvl.sv
module hrf_lvl #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW-1:0] rd_inc,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] wr_inc,
  output logic          empty,
  output logic          full,
  output logic [AW-1:0] level
);
  localparam logic [AW-1:0] DEPTH_M = AW'(DEPTH);
  logic [AW-1:0] lvl_lin, lvl_wrap;

  assign empty = (wr_ptr == rd_inc);
  assign full  = (rd_ptr == wr_inc);

  assign lvl_lin  = wr_ptr - rd_ptr - AW'(1);
  assign lvl_wrap = DEPTH_M - rd_ptr + wr_ptr - AW'(1);
  assign level    = (rd_ptr < wr_ptr) ? lvl_lin : lvl_wrap;
endmodule

// File: rtl/hsk_rd_fifo.sv
module hsk_rd_fifo #(
  parameter int DEPTH = hrf_pkg::HRF_DEPTH,
  parameter int W     = hrf_pkg::HRF_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_req,
  output logic          rd_ack,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic          full,
  output logic [AW-1:0] level
);
  hrf_pkg::hrf_ops_t ops;
  logic [AW-1:0] rd_ptr, rd_inc, wr_ptr, wr_inc;

  assign ops.wr = en & wr_valid & ~full & ~clr;

  hrf_hsk u_hsk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .en     (en),
    .rd_req (rd_req),
    .empty  (empty),
    .rd_take(ops.rd),
    .rd_ack (rd_ack)
  );

  // read pointer names the last consumed slot
  hrf_ptr #(.DEPTH(DEPTH), .RST_VAL(0)) u_rptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .adv    (ops.rd),
    .ptr    (rd_ptr),
    .ptr_inc(rd_inc)
  );

  // write pointer names the next free slot
  hrf_ptr #(.DEPTH(DEPTH), .RST_VAL(1)) u_wptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .adv    (ops.wr),
    .ptr    (wr_ptr),
    .ptr_inc(wr_inc)
  );

  hrf_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .we   (ops.wr),
    .waddr(wr_ptr),
    .wdata(wr_data),
    .re   (ops.rd),
    .raddr(rd_inc),
    .rdata(rd_data)
  );

  hrf_lvl #(.DEPTH(DEPTH)) u_lvl (
    .rd_ptr(rd_ptr),
    .rd_inc(rd_inc),
    .wr_ptr(wr_ptr),
    .wr_inc(wr_inc),
    .empty (empty),
    .full  (full),
    .level (level)
  );
endmodule

// File: rtl/hrf_chk.sv
module hrf_chk #(
  parameter int DEPTH = 1024,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          en,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [W-1:0]  rd_data,
  input logic          empty,
  input logic          full,
  input logic [AW-1:0] level
);
  localparam logic [AW-1:0] MAXLVL = AW'(DEPTH - 2);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R10
  AST_EMPTY_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (level == '0)); // R10
  AST_FULL_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    full == (level == MAXLVL)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr && !(en && rd_req && !rd_ack)) |=> full); // R3
  AST_ACK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && rd_req && !clr) |=> (rd_ack && $stable(rd_data))); // R5
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_ack); // R6
  AST_EMPTY_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rd_ack) |=> !rd_ack); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($stable(rd_data) || $rose(rd_ack))); // R8
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(level) && $stable(rd_data))); // R11
  AST_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (level == $past(level) || level == $past(level) + AW'(1) ||
              level == $past(level) - AW'(1))); // R12
  AST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && level == '0 && !rd_ack && rd_data == '0)); // R13
endmodule

bind hsk_rd_fifo hrf_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr    (clr),
  .en     (en),
  .rd_req (rd_req),
  .rd_ack (rd_ack),
  .rd_data(rd_data),
  .empty  (empty),
  .full   (full),
  .level  (level)
);

// File: tb/hsk_rd_fifo_bench.sv
`timescale 1ns/1ps
module hsk_rd_fifo_bench;
  localparam int DEPTH = 1024;
  localparam int W     = 8;
  localparam int AW    = 10;
  localparam int NV    = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          en = 1'b1;
  logic          wr_valid = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_req = 1'b0;
  logic          rd_ack;
  logic [W-1:0]  rd_data;
  logic          empty;
  logic          full;
  logic [AW-1:0] level;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  hsk_rd_fifo #(.DEPTH(DEPTH), .W(W)) u_hsk_rd_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data), .empty(empty),
    .full(full), .level(level)
  );

  // stimulus {clr,en,wr_valid,wr_data,rd_req} | expect {empty,full,ack,level,data}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,10'd0,8'h00}, // R13 clear
    {1'b0,1'b1,1'b1,8'hA5,1'b0, 1'b0,1'b0,1'b0,10'd1,8'h00}, // R2
    {1'b0,1'b1,1'b1,8'h3C,1'b0, 1'b0,1'b0,1'b0,10'd2,8'h00}, // R2
    {1'b0,1'b1,1'b1,8'h7E,1'b1, 1'b0,1'b0,1'b1,10'd2,8'hA5}, // R12 R4
    {1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b1,10'd2,8'hA5}, // R5
    {1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,10'd2,8'hA5}, // R6
    {1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b1,10'd1,8'h3C}, // R6 R9
    {1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,10'd1,8'h3C}, // R8
    {1'b0,1'b0,1'b1,8'h11,1'b1, 1'b0,1'b0,1'b0,10'd1,8'h3C}, // R11
    {1'b0,1'b1,1'b0,8'h00,1'b1, 1'b1,1'b0,1'b1,10'd0,8'h7E}, // R4
    {1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,10'd0,8'h7E}, // R6
    {1'b0,1'b1,1'b0,8'h00,1'b1, 1'b1,1'b0,1'b0,10'd0,8'h7E}, // R7
    {1'b1,1'b1,1'b1,8'h42,1'b1, 1'b1,1'b0,1'b0,10'd0,8'h00}, // R13
    {1'b0,1'b1,1'b1,8'h42,1'b1, 1'b0,1'b0,1'b0,10'd1,8'h00}  // R7
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R13";  1: return "R2";  2: return "R2";  3: return "R12";
      4: return "R5";   5: return "R6";  6: return "R9";  7: return "R8";
      8: return "R11";  9: return "R4"; 10: return "R6"; 11: return "R7";
      12: return "R13"; default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  task automatic pull(string tag, logic [W-1:0] exp);
    rd_req = 1'b1; tick();
    chk(tag, {31'd0, rd_ack}, 32'd1);
    chk(tag, {24'd0, rd_data}, {24'd0, exp});
    rd_req = 1'b0; tick();
    chk(tag, {31'd0, rd_ack}, 32'd0);
    chk("R8", {24'd0, rd_data}, {24'd0, exp});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    string msg;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1", {20'd0, empty, full, rd_ack, level, rd_data}, {20'd0, 1'b1, 1'b0, 1'b0, 10'd0, 8'h00});

    // vector walk
    for (int i = 0; i < NV; i++) begin
      {clr, en, wr_valid, wr_data, rd_req} = VEC[i][32:21];
      tick();
      chk(vtag(i), {11'd0, empty, full, rd_ack, level, rd_data}, {11'd0, VEC[i][20:0]});
    end
    {clr, wr_valid, rd_req} = '0; en = 1'b1; wr_data = '0;

    // R10: fill to the limit
    do_clear();
    for (int i = 0; i < DEPTH - 2; i++) begin
      wr_valid = 1'b1; wr_data = W'(i) ^ 8'h5A;
      tick();
      if (i == DEPTH - 4) chk("R10", {21'd0, full, level}, {21'd0, 1'b0, 10'(DEPTH - 3)});
    end
    wr_valid = 1'b0;
    chk("R10", {20'd0, empty, full, level}, {20'd0, 1'b0, 1'b1, 10'(DEPTH - 2)});

    // R3: write on full is dropped
    wr_valid = 1'b1; wr_data = 8'hFF; tick(); wr_valid = 1'b0;
    chk("R3", {21'd0, full, level}, {21'd0, 1'b1, 10'(DEPTH - 2)});

    // drain, order and hold (R9 R3 R8)
    for (int i = 0; i < DEPTH - 2; i++) pull("R9", W'(i) ^ 8'h5A);
    chk("R3", {30'd0, empty, full}, {30'd0, 1'b1, 1'b0});

    // R9: message across the pointer wrap
    msg = "Packet-Bytes";
    for (int i = 0; i < msg.len(); i++) begin
      wr_valid = 1'b1; wr_data = msg[i]; tick();
    end
    wr_valid = 1'b0;
    chk("R9", {22'd0, level}, 32'(msg.len()));
    for (int i = 0; i < msg.len(); i++) pull("R9", msg[i]);
    chk("R9", {31'd0, empty}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule